// File: doc/BRIEF.md
# Receive Interface Gain Slicer

This block sits at the end of a receive datapath, just before the output data port. It scales each complex I/Q sample by a power-of-two interface gain of 0, 6, 12 or 18 dB. Each 6 dB step is one arithmetic left shift, and a result that would overflow is clipped to the signed full-scale value. The gain index comes from one of three places. Wideband mode forces it to zero. With external control it is taken from a host-written index. With internal control it is picked by an automatic loop that measures signal power at the block input.

The automatic loop has two paths. The normal path averages I²+Q² over a window of 2^WIN_LOG2 valid samples. At the end of each window it refers that mean to the output by the current gain and compares it against two thresholds. The upper threshold is the programmed maximum level reduced by a peak-to-average margin, and the lower one sits 9 dB below it. The gain then moves by at most one step. The fast-attack path checks every sample on its own. When a single sample, scaled by the current gain, exceeds the maximum level, the gain drops straight to 0 dB for that same sample and the averaging window restarts.

Every output sample carries two tags: a gain-change flag, and a 2-bit field that holds either the active gain index or zeros.

Top module: `rx_ifgain_slicer`

## Requirements
- R1: When `wideband` is 1, every output sample equals its input sample and `out_gidx` is 0, whatever `ext_ctrl` and `man_gain` are.
- R2: In narrowband mode with `ext_ctrl` = 1, each output sample is its input shifted left by `man_gain` bits (gain index g means 6·g dB), and `out_gidx` equals `man_gain`.
- R3: A shifted value above 2^(DW-1)-1 is output as 2^(DW-1)-1, and one below -2^(DW-1) is output as -2^(DW-1); a shifted value inside that range is output exactly.
- R4: `out_valid` is `in_valid` delayed by one clock, and the output data belong to the sample presented one clock earlier.
- R5: With internal control in narrowband mode, once a window of 2^WIN_LOG2 valid samples ends with the gain-referred mean power (mean of I²+Q² multiplied by 4^g) below `(max_level >> papr_sh) >> 3`, the gain index goes up by one, starting with the next sample.
- R6: With internal control, once a window ends with the gain-referred mean power above `max_level >> papr_sh` and the gain index is above 0, the gain index goes down by one, starting with the next sample.
- R7: With internal control and a gain index above 0, a sample whose I²+Q² multiplied by 4^g exceeds `max_level` is output at gain index 0, together with the samples that follow it. The averaging window restarts after that sample.
- R8: `out_chg` is 1 on exactly the first output sample whose applied gain index differs from that of the previous output sample (the gain before the first sample counts as 0), and 0 on every other sample.
- R9: When `tag_en` is 0, `out_gidx` is 0 while the data shift and `out_chg` still follow the applied gain.
- R10: During and right after reset, `out_valid` and `out_chg` are 0, `out_gidx` is 0, and the automatic gain index starts at 0.
- R11: The automatic gain index holds its value across a window whose gain-referred mean power lies between the two thresholds, and it never moves by more than one step per window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | DW | Input in-phase sample, signed |
| in_q | input | DW | Input quadrature sample, signed |
| wideband | input | 1 | 1 = wideband mode, gain forced to 0 dB |
| ext_ctrl | input | 1 | 1 = host index, 0 = automatic loop |
| man_gain | input | 2 | Host gain index, 6 dB per step |
| tag_en | input | 1 | 1 = gain field carries the index, 0 = zeros |
| max_level | input | 2·DW | Maximum output power level |
| papr_sh | input | 3 | Peak-to-average margin, right shift of max_level |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | DW | Scaled in-phase sample |
| out_q | output | DW | Scaled quadrature sample |
| out_chg | output | 1 | Gain-change flag for this sample |
| out_gidx | output | 2 | Applied gain index or zeros |

## Verification
The main function is tried with four kinds of pattern. In wideband mode, steady host indices separate the pass-through path from the host path. Steps of the host index show the shift amount and place the change flag on the right sample. Large positive and negative values separate clipping from wrapping. Constant tones of a chosen amplitude, fed to the automatic loop, move the gain up window by window until it rests inside the hysteresis band; a louder tone then steps it down, and a single loud sample shows whether the fast-attack drop lands on that sample or one later.

// File: rtl/rx_ifgain_pkg.sv
package rx_ifgain_pkg;
  typedef logic [1:0] gidx_t;
  localparam gidx_t GIDX_MAX  = 2'd3;
  localparam int    SCALE_EXT = 6;
endpackage

// File: rtl/rx_ifgain_shift.sv
module rx_ifgain_shift #(
  parameter int DW = 16
) (
  input  logic signed [DW-1:0]  din,
  input  rx_ifgain_pkg::gidx_t  sh,
  output logic signed [DW-1:0]  dout
);
  localparam int WW = DW + 3;

  logic signed [WW-1:0] wide;
  logic                 ovf;

  always_comb begin
    wide = WW'(din) <<< sh;
    ovf  = !((&wide[WW-1:DW-1]) || !(|wide[WW-1:DW-1]));
    if (ovf)
      dout = wide[WW-1] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
    else
      dout = wide[DW-1:0];
  end
endmodule

// File: rtl/rx_ifgain_agc.sv
module rx_ifgain_agc #(
  parameter int DW       = 16,
  parameter int WIN_LOG2 = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en,
  input  logic                   smp_valid,
  input  logic signed [DW-1:0]   smp_i,
  input  logic signed [DW-1:0]   smp_q,
  input  logic [2*DW-1:0]        max_level,
  input  logic [2:0]             papr_sh,
  output rx_ifgain_pkg::gidx_t   auto_g,
  output logic                   fa_hit
);
  import rx_ifgain_pkg::*;
  localparam int PW = 2 * DW;
  localparam int AW = PW + WIN_LOG2;
  localparam int SW = PW + SCALE_EXT;

  logic signed [PW-1:0] sq_i, sq_q;
  logic [PW-1:0]        pwr;
  logic [SW-1:0]        pwr_scaled, mean_scaled;
  logic [AW-1:0]        acc, acc_next;
  logic [PW-1:0]        mean, hi_thr, lo_thr;
  logic [WIN_LOG2-1:0]  cnt;
  logic                 win_end;

  always_comb begin
    sq_i        = PW'(smp_i) * PW'(smp_i);
    sq_q        = PW'(smp_q) * PW'(smp_q);
    pwr         = $unsigned(sq_i) + $unsigned(sq_q);
    pwr_scaled  = SW'(pwr) << {auto_g, 1'b0};
    acc_next    = acc + AW'(pwr);
    mean        = acc_next[AW-1:WIN_LOG2];
    mean_scaled = SW'(mean) << {auto_g, 1'b0};
    hi_thr      = max_level >> papr_sh;
    lo_thr      = hi_thr >> 3;
    win_end     = &cnt;
    fa_hit      = en && smp_valid && (auto_g != 2'd0) && (pwr_scaled > SW'(max_level));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      auto_g <= '0;
      acc    <= '0;
      cnt    <= '0;
    end else if (!en) begin
      acc <= '0;
      cnt <= '0;
    end else if (smp_valid) begin
      if (fa_hit) begin
        auto_g <= '0;
        acc    <= '0;
        cnt    <= '0;
      end else if (win_end) begin
        acc <= '0;
        cnt <= '0;
        if (mean_scaled > SW'(hi_thr) && auto_g != 2'd0)
          auto_g <= auto_g - 2'd1;
        else if (mean_scaled < SW'(lo_thr) && auto_g != GIDX_MAX)
          auto_g <= auto_g + 2'd1;
      end else begin
        acc <= acc_next;
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rx_ifgain_slicer.sv
module rx_ifgain_slicer #(
  parameter int DW       = 16,
  parameter int WIN_LOG2 = 4,
  parameter int PW       = 2 * DW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  input  logic                 wideband,
  input  logic                 ext_ctrl,
  input  logic [1:0]           man_gain,
  input  logic                 tag_en,
  input  logic [PW-1:0]        max_level,
  input  logic [2:0]           papr_sh,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_i,
  output logic signed [DW-1:0] out_q,
  output logic                 out_chg,
  output logic [1:0]           out_gidx
);
  import rx_ifgain_pkg::*;
  localparam int LANES = 2;

  gidx_t                auto_g, eff_g, last_g;
  logic                 fa_hit, auto_en;
  logic signed [DW-1:0] lane_in  [LANES];
  logic signed [DW-1:0] lane_out [LANES];

  assign auto_en    = !wideband && !ext_ctrl;
  assign lane_in[0] = in_i;
  assign lane_in[1] = in_q;

  rx_ifgain_agc #(.DW(DW), .WIN_LOG2(WIN_LOG2)) u_agc (
    .clk(clk), .rst(rst), .en(auto_en), .smp_valid(in_valid),
    .smp_i(in_i), .smp_q(in_q), .max_level(max_level), .papr_sh(papr_sh),
    .auto_g(auto_g), .fa_hit(fa_hit)
  );

  always_comb begin
    if (wideband)      eff_g = '0;
    else if (ext_ctrl) eff_g = man_gain;
    else if (fa_hit)   eff_g = '0;
    else               eff_g = auto_g;
  end

  generate
    for (genvar k = 0; k < LANES; k++) begin : g_lane
      rx_ifgain_shift #(.DW(DW)) u_shift (
        .din(lane_in[k]), .sh(eff_g), .dout(lane_out[k])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
      out_chg   <= 1'b0;
      out_gidx  <= '0;
      last_g    <= '0;
    end else begin
      out_valid <= in_valid;
      out_chg   <= 1'b0;
      if (in_valid) begin
        out_i    <= lane_out[0];
        out_q    <= lane_out[1];
        out_chg  <= (eff_g != last_g);
        out_gidx <= tag_en ? eff_g : 2'd0;
        last_g   <= eff_g;
      end
    end
  end
endmodule

// File: rtl/rx_ifgain_slicer_chk.sv
module rx_ifgain_slicer_chk #(
  parameter int DW = 16,
  parameter int PW = 2 * DW
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic signed [DW-1:0] in_i,
  input logic signed [DW-1:0] in_q,
  input logic                 wideband,
  input logic                 ext_ctrl,
  input logic [1:0]           man_gain,
  input logic                 tag_en,
  input logic [PW-1:0]        max_level,
  input logic                 out_valid,
  input logic signed [DW-1:0] out_i,
  input logic signed [DW-1:0] out_q,
  input logic                 out_chg,
  input logic [1:0]           out_gidx
);
  assert_lat_R4: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_idle_R4: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_wb_pass_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid && wideband |=> out_i == $past(in_i) && out_q == $past(in_q) && out_gidx == 2'd0);
  assert_ext_idx_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid && !wideband && ext_ctrl && tag_en |=> out_gidx == $past(man_gain));
  assert_sign_kept_R3: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_i != '0 |=> out_i != '0 && out_i[DW-1] == $past(in_i[DW-1]));
  assert_tag_zero_R9: assert property (@(posedge clk) disable iff (rst)
    in_valid && !tag_en |=> out_gidx == 2'd0);
  assert_chg_valid_R8: assert property (@(posedge clk) disable iff (rst)
    out_chg |-> out_valid);
endmodule

bind rx_ifgain_slicer rx_ifgain_slicer_chk #(.DW(DW), .PW(PW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
  .wideband(wideband), .ext_ctrl(ext_ctrl), .man_gain(man_gain), .tag_en(tag_en),
  .max_level(max_level), .out_valid(out_valid), .out_i(out_i), .out_q(out_q),
  .out_chg(out_chg), .out_gidx(out_gidx)
);

// File: tb/test_rx_ifgain_slicer.sv
module test_rx_ifgain_slicer;
  localparam int DW = 16;
  localparam int PW = 2 * DW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [DW-1:0] in_i = '0, in_q = '0;
  logic wideband = 1'b0, ext_ctrl = 1'b0, tag_en = 1'b1;
  logic [1:0] man_gain = '0;
  logic [PW-1:0] max_level = PW'(1) << 30;
  logic [2:0] papr_sh = 3'd2;
  logic out_valid, out_chg;
  logic signed [DW-1:0] out_i, out_q;
  logic [1:0] out_gidx;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  rx_ifgain_slicer #(.DW(DW), .WIN_LOG2(4)) i_rx_ifgain_slicer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .wideband(wideband), .ext_ctrl(ext_ctrl), .man_gain(man_gain), .tag_en(tag_en),
    .max_level(max_level), .papr_sh(papr_sh), .out_valid(out_valid), .out_i(out_i),
    .out_q(out_q), .out_chg(out_chg), .out_gidx(out_gidx)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int i, input int q);
    in_valid = 1'b1;
    in_i = DW'(i);
    in_q = DW'(q);
    @(negedge clk);
  endtask

  task automatic do_reset;
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10", "out_valid in reset", int'(out_valid), 0);
    chk("R10", "out_chg in reset", int'(out_chg), 0);
    chk("R10", "out_gidx in reset", int'(out_gidx), 0);
    rst = 1'b0;
  endtask

  task automatic t_reset;
    wideband = 0; ext_ctrl = 0; tag_en = 1;
    do_reset();
    step(100, -100);
    chk("R10", "auto gain after reset", int'(out_gidx), 0);
    chk("R10", "data after reset", int'(out_i), 100);
    chk("R8", "no change on first sample", int'(out_chg), 0);
  endtask

  task automatic t_wideband;
    do_reset();
    wideband = 1; ext_ctrl = 1; man_gain = 3;
    step(1234, -4321);
    chk("R1", "wb i", int'(out_i), 1234);
    chk("R1", "wb q", int'(out_q), -4321);
    chk("R1", "wb gidx", int'(out_gidx), 0);
    ext_ctrl = 0;
    step(-32768, 32767);
    chk("R1", "wb internal i", int'(out_i), -32768);
    chk("R1", "wb internal q", int'(out_q), 32767);
    wideband = 0;
  endtask

  task automatic t_external;
    do_reset();
    ext_ctrl = 1; man_gain = 2;
    step(-300, 77);
    chk("R2", "ext i", int'(out_i), -1200);
    chk("R2", "ext q", int'(out_q), 308);
    chk("R2", "ext gidx", int'(out_gidx), 2);
    chk("R8", "chg on first new gain", int'(out_chg), 1);
    step(10, 10);
    chk("R8", "no chg on repeat", int'(out_chg), 0);
    man_gain = 1;
    step(5, -5);
    chk("R2", "ext gain 1 i", int'(out_i), 10);
    chk("R8", "chg on step to 1", int'(out_chg), 1);
  endtask

  task automatic t_saturate;
    do_reset();
    ext_ctrl = 1; man_gain = 3;
    step(5000, -5000);
    chk("R3", "clip positive", int'(out_i), 32767);
    chk("R3", "clip negative", int'(out_q), -32768);
    step(4095, -4096);
    chk("R3", "exact positive", int'(out_i), 32760);
    chk("R3", "exact negative", int'(out_q), -32768);
  endtask

  task automatic t_latency;
    do_reset();
    ext_ctrl = 1; man_gain = 0;
    in_valid = 0;
    @(negedge clk);
    chk("R4", "idle out_valid", int'(out_valid), 0);
    step(42, 43);
    chk("R4", "out_valid after one clock", int'(out_valid), 1);
    chk("R4", "data after one clock", int'(out_q), 43);
    in_valid = 0;
    @(negedge clk);
    chk("R4", "out_valid drops", int'(out_valid), 0);
  endtask

  task automatic t_tag;
    do_reset();
    ext_ctrl = 1; man_gain = 2; tag_en = 0;
    step(100, 0);
    chk("R9", "gidx zero", int'(out_gidx), 0);
    chk("R9", "data still shifted", int'(out_i), 400);
    chk("R9", "chg still flagged", int'(out_chg), 1);
    tag_en = 1;
  endtask

  task automatic ramp_up(input string req);
    for (int k = 0; k < 64; k++) begin
      automatic int g = (k < 48) ? k / 16 : 3;
      step(1000, 1000);
      chk(req, "ramp gain", int'(out_gidx), g);
      chk(req, "ramp data", int'(out_i), 1000 <<< g);
      chk("R8", "ramp chg", int'(out_chg), (k == 16 || k == 32 || k == 48) ? 1 : 0);
    end
  endtask

  task automatic t_auto;
    do_reset();
    ext_ctrl = 0; wideband = 0;
    ramp_up("R5");
    for (int k = 0; k < 16; k++) begin
      step(1000, 1000);
      chk("R11", "hold in band", int'(out_gidx), 3);
    end
    for (int k = 0; k < 32; k++) begin
      step(1600, 1600);
      chk("R6", "step down gain", int'(out_gidx), (k < 16) ? 3 : 2);
      chk("R6", "step down chg", int'(out_chg), (k == 16) ? 1 : 0);
    end
  endtask

  task automatic t_fast;
    do_reset();
    ext_ctrl = 0;
    ramp_up("R5");
    step(4000, 4000);
    chk("R7", "fast attack data", int'(out_i), 4000);
    chk("R7", "fast attack gidx", int'(out_gidx), 0);
    chk("R8", "fast attack chg", int'(out_chg), 1);
    for (int k = 0; k < 17; k++) begin
      step(1000, 1000);
      chk("R7", "gain after attack", int'(out_gidx), (k < 16) ? 0 : 1);
      chk("R7", "chg after attack", int'(out_chg), (k == 16) ? 1 : 0);
    end
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_wideband();
    t_external();
    t_saturate();
    t_latency();
    t_tag();
    t_auto();
    t_fast();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule